// File: doc/BRIEF.md
# Handshaked Two-Tap Averaging Filter

This block is a streaming filter that takes one sample at a time from an input channel and emits the mean of that sample and the sample before it on an output channel. Both channels use four-phase request/acknowledge handshakes. The block is a clocked model of a self-timed controller. The controller steps through four internal units in a fixed order, and each unit has its own request/acknowledge pair. The units are a capture latch for the new sample, a history latch holding the previous sample, an adder with a fixed completion delay, and an output register.

For each sample the controller runs these steps in order. It opens the capture latch and waits for that latch's acknowledge. It then acknowledges the input, so the environment may move on. Next it requests the adder and waits a parameterised number of cycles for the adder's completion. It loads the output register and raises the output request. Only after the output acknowledge arrives does it copy the new sample into the history latch. It then returns every internal pair to zero and releases the input acknowledge. The sum is one bit wider than a sample and the division by two truncates.

Top module: `pmf_filter`

## Requirements
- R1: After reset, `in_ack` and `out_req` are 0, `out_data` is 0 and the stored previous sample is 0.
- R2: The first output after a reset equals the input sample shifted right by one bit, because the stored previous sample is 0.
- R3: Each output equals bits W..1 of the (W+1)-bit sum of the current sample and the previous sample. After each output, the current sample becomes the previous sample.
- R4: `in_ack` rises only while `in_req` is high. Once high, `in_ack` stays high while `in_req` is high.
- R5: `out_data` holds a valid result whenever `out_req` is high and stays unchanged until `out_req` falls. `out_req` stays high until `out_ack` is seen high. `out_req` does not rise again while `out_ack` is still high.
- R6: `out_req` rises exactly ADD_DELAY+1 clock cycles after `in_ack` rises.
- R7: While an output handshake is pending (`out_req` high), `in_ack` stays high, so no new sample is accepted. The previous sample is replaced only after `out_ack` rises.
- R8: Samples sent back to back produce their averages in input order, exactly one output per input, with none dropped or repeated.
- R9: Changing `in_data` after `in_ack` has risen has no effect on the result for that sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | 1 | Input request; marks `in_data` valid |
| in_data | input | W | Input sample |
| in_ack | output | 1 | Input acknowledge |
| out_req | output | 1 | Output request; marks `out_data` valid |
| out_data | output | W | Averaged result |
| out_ack | input | 1 | Output acknowledge from the consumer |

## Verification
Two events can land in the same cycle. In one, the environment changes the input the moment `in_ack` is seen while the capture latch is closing. In the other, `out_ack` rises while the history latch has yet to be updated. The bench flips `in_data` at the very sample point where it first sees `in_ack` high. It also delays `out_ack` by several different counts and then raises it. Correctness is judged by the value of the next output. That value can only be right if the capture used the old input and the history update waited for the acknowledge. While `out_ack` is held off, the bench also confirms that `in_ack` stays high.

// File: rtl/pmf_pkg.sv
package pmf_pkg;

    localparam int unsigned PMF_DEF_WIDTH = 8;
    localparam int unsigned PMF_DEF_DELAY = 3;

    // controller phases, visited in this order per sample
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_CAPTURE = 3'd1,
        PH_ADD     = 3'd2,
        PH_PRESENT = 3'd3,
        PH_HISTORY = 3'd4,
        PH_RETURN  = 3'd5
    } phase_t;

    // one internal request/acknowledge pair
    typedef struct packed {
        logic req;
        logic ack;
    } hs_pair_t;

endpackage

// File: rtl/pmf_latch.sv
module pmf_latch #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  logic [W-1:0] d,
    output logic         ack,
    output logic [W-1:0] q
);
    // follows d while req is high, holds while low; ack trails req by a cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            ack <= 1'b0;
        end else begin
            ack <= req;
            if (req) q <= d;
        end
    end
endmodule

// File: rtl/pmf_adder.sv
module pmf_adder #(
    parameter int unsigned W     = 8,
    parameter int unsigned DELAY = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         ack,
    output logic [W-1:0] mean
);
    localparam int unsigned CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);

    logic [W:0]    wide_sum;
    logic [CW-1:0] cnt;

    assign wide_sum = {1'b0, a} + {1'b0, b};
    assign mean     = wide_sum[W:1];

    // matched delay: ack rises DELAY edges after req is first seen
    always_ff @(posedge clk) begin
        if (rst || !req) begin
            cnt <= '0;
            ack <= 1'b0;
        end else if (!ack) begin
            if (cnt == CW'(DELAY - 1)) ack <= 1'b1;
            else                       cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pmf_outreg.sv
module pmf_outreg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/pmf_ctrl.sv
module pmf_ctrl
    import pmf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_req,
    input  logic out_ack,
    input  logic cap_ack,
    input  logic add_ack,
    input  logic hist_ack,
    output logic cap_req,
    output logic add_req,
    output logic hist_req,
    output logic load,
    output logic in_ack,
    output logic out_req
);
    phase_t ph, ph_nx;

    always_comb begin
        ph_nx = ph;
        unique case (ph)
            PH_IDLE:    if (in_req)   ph_nx = PH_CAPTURE;
            PH_CAPTURE: if (cap_ack)  ph_nx = PH_ADD;
            PH_ADD:     if (add_ack)  ph_nx = PH_PRESENT;
            PH_PRESENT: if (out_ack)  ph_nx = PH_HISTORY;
            PH_HISTORY: if (hist_ack) ph_nx = PH_RETURN;
            PH_RETURN:  if (!in_req && !out_ack && !cap_ack && !add_ack && !hist_ack)
                            ph_nx = PH_IDLE;
            default:    ph_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph <= PH_IDLE;
        else     ph <= ph_nx;
    end

    assign cap_req  = (ph == PH_CAPTURE);
    assign add_req  = (ph == PH_ADD);
    assign hist_req = (ph == PH_HISTORY);
    assign out_req  = (ph == PH_PRESENT);
    assign load     = (ph == PH_ADD) && add_ack;
    assign in_ack   = (ph == PH_ADD) || (ph == PH_PRESENT) ||
                      (ph == PH_HISTORY) || (ph == PH_RETURN);
endmodule

// File: rtl/pmf_filter.sv
module pmf_filter
    import pmf_pkg::*;
#(
    parameter int unsigned W         = PMF_DEF_WIDTH,
    parameter int unsigned ADD_DELAY = PMF_DEF_DELAY
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_req,
    input  logic [W-1:0] in_data,
    output logic         in_ack,
    output logic         out_req,
    output logic [W-1:0] out_data,
    input  logic         out_ack
);
    hs_pair_t     cap_hs, hist_hs, add_hs;
    logic         load;
    logic [W-1:0] cur_q, prev_q, mean;

    pmf_ctrl ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .in_req   (in_req),
        .out_ack  (out_ack),
        .cap_ack  (cap_hs.ack),
        .add_ack  (add_hs.ack),
        .hist_ack (hist_hs.ack),
        .cap_req  (cap_hs.req),
        .add_req  (add_hs.req),
        .hist_req (hist_hs.req),
        .load     (load),
        .in_ack   (in_ack),
        .out_req  (out_req)
    );

    pmf_latch #(.W(W)) cap_i (
        .clk (clk), .rst (rst), .req (cap_hs.req),
        .d (in_data), .ack (cap_hs.ack), .q (cur_q)
    );

    pmf_latch #(.W(W)) hist_i (
        .clk (clk), .rst (rst), .req (hist_hs.req),
        .d (cur_q), .ack (hist_hs.ack), .q (prev_q)
    );

    pmf_adder #(.W(W), .DELAY(ADD_DELAY)) add_i (
        .clk (clk), .rst (rst), .req (add_hs.req),
        .a (cur_q), .b (prev_q), .ack (add_hs.ack), .mean (mean)
    );

    pmf_outreg #(.W(W)) out_i (
        .clk (clk), .rst (rst), .load (load), .d (mean), .q (out_data)
    );
endmodule

// File: rtl/pmf_filter_chk.sv
module pmf_filter_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         in_req,
    input logic         in_ack,
    input logic         out_req,
    input logic         out_ack,
    input logic [W-1:0] out_data
);
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!in_ack && !out_req && out_data == '0));

    assert_ack_needs_req_R4: assert property (@(posedge clk) disable iff (rst)
        (!in_ack && !in_req) |=> !in_ack);

    assert_ack_held_R4: assert property (@(posedge clk) disable iff (rst)
        (in_ack && in_req) |=> in_ack);

    assert_data_stable_R5: assert property (@(posedge clk) disable iff (rst)
        out_req |=> (!out_req || $stable(out_data)));

    assert_req_waits_ack_R5: assert property (@(posedge clk) disable iff (rst)
        (out_req && !out_ack) |=> out_req);

    assert_no_rerequest_R5: assert property (@(posedge clk) disable iff (rst)
        (!out_req && out_ack) |=> !out_req);

    assert_input_blocked_R7: assert property (@(posedge clk) disable iff (rst)
        out_req |-> in_ack);
endmodule

bind pmf_filter pmf_filter_chk #(.W(W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .in_req   (in_req),
    .in_ack   (in_ack),
    .out_req  (out_req),
    .out_ack  (out_ack),
    .out_data (out_data)
);

// File: tb/pmf_filter_tb.sv
module pmf_filter_tb_top;
    localparam int unsigned W  = 8;
    localparam int unsigned AD = 3;
    localparam int          NV = 8;

    // {input sample, expected mean, output-ack delay}
    localparam logic [7:0] VEC [NV][3] = '{
        '{8'd100, 8'd50,  8'd0},
        '{8'd50,  8'd75,  8'd2},
        '{8'd255, 8'd152, 8'd5},
        '{8'd255, 8'd255, 8'd1},
        '{8'd0,   8'd127, 8'd0},
        '{8'd1,   8'd0,   8'd3},
        '{8'd3,   8'd2,   8'd7},
        '{8'd200, 8'd101, 8'd0}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_req = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         in_ack;
    logic         out_req;
    logic [W-1:0] out_data;
    logic         out_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pmf_filter #(.W(W), .ADD_DELAY(AD)) dut_i (
        .clk (clk), .rst (rst), .in_req (in_req), .in_data (in_data),
        .in_ack (in_ack), .out_req (out_req), .out_data (out_data),
        .out_ack (out_ack)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic send(input logic [W-1:0] smp, input logic [W-1:0] exp,
                        input int ack_wait, input string tag);
        int t_ack;
        @(negedge clk);
        in_data = smp;
        in_req  = 1'b1;
        while (!in_ack) @(negedge clk);
        t_ack   = cyc;
        in_data = ~smp;   // R9: input changes as soon as acknowledged
        in_req  = 1'b0;
        while (!out_req) @(negedge clk);
        check({"R6 latency ", tag}, cyc - t_ack, AD + 1);
        check({"R3 R8 R9 mean ", tag}, out_data, exp);
        for (int k = 0; k < ack_wait; k++) begin
            @(negedge clk);
            check({"R5 hold ", tag}, out_data, exp);
            check({"R7 input blocked ", tag}, in_ack, 1);
        end
        out_ack = 1'b1;
        while (out_req) @(negedge clk);
        out_ack = 1'b0;
        while (in_ack) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset
        check("R1 in_ack", in_ack, 0);
        check("R1 out_req", out_req, 0);
        check("R1 out_data", out_data, 0);
        repeat (4) @(negedge clk);
        check("R4 no ack without req", in_ack, 0);

        // main stream, averages in order (R2 for first, R3/R8 for all)
        for (int i = 0; i < NV; i++)
            send(VEC[i][0], VEC[i][1], int'(VEC[i][2]), $sformatf("v%0d", i));

        // one more with previous sample 200
        send(8'd40, 8'd120, 2, "after stream");

        // mid-stream reset clears the history (R1, R2)
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 in_ack after reset", in_ack, 0);
        check("R1 out_req after reset", out_req, 0);
        send(8'd40, 8'd20, 1, "R2 first after reset");
        send(8'd41, 8'd40, 4, "R3 odd sum truncates");

        // R4: held request keeps acknowledge high
        @(negedge clk);
        in_data = 8'd10;
        in_req  = 1'b1;
        while (!in_ack) @(negedge clk);
        while (!out_req) @(negedge clk);
        check("R3 held req mean", out_data, 25);
        out_ack = 1'b1;
        while (out_req) @(negedge clk);
        out_ack = 1'b0;
        repeat (5) @(negedge clk);
        check("R4 ack held while req high", in_ack, 1);
        in_req = 1'b0;
        while (in_ack) @(negedge clk);
        send(8'd30, 8'd20, 0, "R8 after held req");

        finish_run();
    end
endmodule